// File: doc/BRIEF.md
# Serial NOR Flash Command Sequencer

This block is a four-wire SPI master that carries out modifying and power commands on a serial NOR flash for a host. The host fills a byte buffer through a simple write port. It then posts one command on a valid/ready port: page program, sector erase, bulk erase, power-down entry or power-down exit. The block builds every chip-select frame that the command needs. Before each program or erase it sends a stand-alone write-enable frame. After the modifying frame it reads the status register repeatedly until the busy bit drops. It finishes with a one-cycle `done` pulse, or with an `err` pulse if the command was refused or polling ran out.

The serial clock comes from the system clock through a divider. Clock polarity is chosen per command by a configuration input, which gives mode 0 (idle low) or mode 3 (idle high). In both modes the block changes its data output on falling edges and samples the flash output on rising edges. Chip select stays high for a fixed guard interval after every frame.

Top module: `sflash_ctrl`

## Requirements
- R1: While reset is active and right after it, `cs_n` is 1, `sck` sits at its idle level, `cmd_ready` is 1, and `done` and `err` are 0.
- R2: Whenever `cs_n` is high, `sck` equals `cpol` (0 gives mode 0, 1 gives mode 3).
- R3: Each byte goes out MSB first. `mosi` changes only while `sck` is low and never on a rising edge. The flash output is sampled on rising edges.
- R4: Page program (op 0), sector erase (op 1) and bulk erase (op 2) are each preceded by a frame that holds only the byte 06h.
- R5: A page program frame is 02h, then the 24-bit address (high byte first), then `cmd_len` data bytes taken from buffer entries 0 up to `cmd_len`-1.
- R6: A sector erase frame is D8h followed by the 24-bit address. A bulk erase frame is the single byte C7h.
- R7: A page program with `cmd_len` 0, or with the low address byte plus `cmd_len` above 256, is refused with `err` and produces no frame. Ending exactly on the page end is accepted.
- R8: After a program or erase frame, the block sends status-read frames (05h followed by a 00h dummy byte). It stops once a frame returns bit 0 of the status byte as 0, and then pulses `done`. The other status bits are ignored.
- R9: If `POLL_LIMIT` status reads in a row all show bit 0 set, the block stops polling and pulses `err`.
- R10: Between any two frames, `cs_n` stays high for at least 4·`CLK_DIV` system cycles, which is two serial clock periods.
- R11: Op 3 sends the single byte B9h and enters power-down. While in power-down, any op other than 4 is refused with `err` and produces no frame. Op 4 sends ABh and leaves power-down.
- R12: Op codes 5 to 7 are refused with `err` and produce no frame.
- R13: `cmd_ready` is low while a command is in progress, and no frame is ever open while it is high. Each command produces exactly one pulse, either `done` or `err`, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpol | input | 1 | Serial clock idle level: 0 for mode 0, 1 for mode 3 |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Block idle, command accepted |
| cmd_op | input | 3 | 0 program, 1 sector erase, 2 bulk erase, 3 power-down, 4 wake |
| cmd_addr | input | 24 | Flash byte address |
| cmd_len | input | 9 | Program byte count, 1 to 256 |
| wr_en | input | 1 | Buffer write strobe |
| wr_addr | input | 8 | Buffer entry index |
| wr_data | input | 8 | Buffer write data |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle refusal or poll-timeout pulse |
| sck | output | 1 | Serial clock to the flash |
| cs_n | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash |
| miso | input | 1 | Serial data from the flash |

## Verification
The bench sends a page program that ends exactly on the page end and one that goes one byte past it. A design with an off-by-one in the page check would either refuse a legal program or send a frame that wraps inside the page. The bench runs a full 256-byte program in mode 3, where an index or length counter that is one bit too narrow would cut the data stream short. It returns status bytes whose upper bits are all set, so a design that tested the whole byte would never finish. It keeps the busy bit set long enough to hit the poll limit, where a design with a wrong counter would either hang or stop early. Finally it issues erase and program requests during power-down, and any frame sent in that state would show up in the frame capture.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int ADDR_W = 24;

  localparam logic [2:0] OP_PROG  = 3'd0;
  localparam logic [2:0] OP_SECT  = 3'd1;
  localparam logic [2:0] OP_BULK  = 3'd2;
  localparam logic [2:0] OP_SLEEP = 3'd3;
  localparam logic [2:0] OP_WAKE  = 3'd4;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_PROG  = 8'h02;
  localparam logic [7:0] OPC_SECT  = 8'hD8;
  localparam logic [7:0] OPC_BULK  = 8'hC7;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_SLEEP = 8'hB9;
  localparam logic [7:0] OPC_WAKE  = 8'hAB;

  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_WAIT, ST_GAP} st_e;
  typedef enum logic [1:0] {PH_WEN, PH_MAIN, PH_POLL} ph_e;

  function automatic logic [7:0] main_opc(input logic [2:0] op);
    case (op)
      OP_PROG:  return OPC_PROG;
      OP_SECT:  return OPC_SECT;
      OP_BULK:  return OPC_BULK;
      OP_SLEEP: return OPC_SLEEP;
      default:  return OPC_WAKE;
    endcase
  endfunction

  function automatic logic is_modify(input logic [2:0] op);
    return (op == OP_PROG) || (op == OP_SECT) || (op == OP_BULK);
  endfunction
endpackage

// File: rtl/sfc_buf.sv
module sfc_buf #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_addr] <= wr_data;
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/sfc_shifter.sv
module sfc_shifter #(
  parameter int CLK_DIV = 2,
  localparam int DW = $clog2(CLK_DIV + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpol,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic       rx_last
);
  logic          busy_q, busy_n;
  logic          half_q, half_n;
  logic [2:0]    bit_q, bit_n;
  logic [DW-1:0] div_q, div_n;
  logic [7:0]    tx_q, tx_n;
  logic          rx_q, rx_n;
  logic          done_q, done_n;
  logic          tick;

  assign tick = busy_q && (div_q == DW'(CLK_DIV - 1));

  always_comb begin
    busy_n = busy_q;
    half_n = half_q;
    bit_n  = bit_q;
    tx_n   = tx_q;
    rx_n   = rx_q;
    done_n = 1'b0;
    div_n  = (busy_q && !tick) ? div_q + DW'(1) : '0;
    if (start && !busy_q) begin
      busy_n = 1'b1;
      half_n = 1'b0;
      bit_n  = '0;
      tx_n   = tx_byte;
    end else if (tick) begin
      if (!half_q) begin
        half_n = 1'b1;
        rx_n   = miso;
      end else begin
        half_n = 1'b0;
        if (bit_q == 3'd7) begin
          busy_n = 1'b0;
          done_n = 1'b1;
        end else begin
          bit_n = bit_q + 3'd1;
          tx_n  = {tx_q[6:0], 1'b0};
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      half_q <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      tx_q   <= '0;
      rx_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_n;
      half_q <= half_n;
      bit_q  <= bit_n;
      div_q  <= div_n;
      tx_q   <= tx_n;
      rx_q   <= rx_n;
      done_q <= done_n;
    end
  end

  assign sck       = busy_q ? half_q : cpol;
  assign mosi      = tx_q[7];
  assign byte_done = done_q;
  assign rx_last   = rx_q;
endmodule

// File: rtl/sflash_ctrl.sv
module sflash_ctrl
  import sfc_pkg::*;
#(
  parameter int CLK_DIV    = 2,
  parameter int POLL_LIMIT = 8,
  parameter int PAGE       = 256,
  localparam int BW  = $clog2(PAGE),
  localparam int LW  = BW + 1,
  localparam int GAP = 4 * CLK_DIV,
  localparam int GW  = $clog2(GAP + 1),
  localparam int PW  = $clog2(POLL_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpol,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [LW-1:0]     cmd_len,
  input  logic              wr_en,
  input  logic [BW-1:0]     wr_addr,
  input  logic [7:0]        wr_data,
  output logic              done,
  output logic              err,
  output logic              sck,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  logic [1:0] rsync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_i_n = rsync_q[1];

  st_e               st_q, st_n;
  ph_e               ph_q, ph_n;
  logic [2:0]        op_q, op_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [LW-1:0]     len_q, len_n;
  logic [LW-1:0]     idx_q, idx_n;
  logic [GW-1:0]     gap_q, gap_n;
  logic [PW-1:0]     poll_q, poll_n;
  logic              pd_q, pd_n;
  logic              wip_q, wip_n;
  logic              done_q, done_n;
  logic              err_q, err_n;

  logic              start, byte_done, rx_last;
  logic [7:0]        tx, buf_rd;
  logic [LW-1:0]     flen;
  logic [LW:0]       end_off;
  logic              bad;

  sfc_buf #(.DEPTH(PAGE)) u_buf (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (BW'(idx_q - LW'(4))),
    .rd_data (buf_rd)
  );

  sfc_shifter #(.CLK_DIV(CLK_DIV)) u_shf (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .cpol      (cpol),
    .start     (start),
    .tx_byte   (tx),
    .miso      (miso),
    .sck       (sck),
    .mosi      (mosi),
    .byte_done (byte_done),
    .rx_last   (rx_last)
  );

  // Frame length in bytes for the current phase.
  always_comb begin
    case (ph_q)
      PH_WEN:  flen = LW'(1);
      PH_POLL: flen = LW'(2);
      default: begin
        if (op_q == OP_PROG)      flen = LW'(4) + len_q;
        else if (op_q == OP_SECT) flen = LW'(4);
        else                      flen = LW'(1);
      end
    endcase
  end

  // Byte presented to the shifter for the current frame position.
  always_comb begin
    tx = 8'h00;
    case (ph_q)
      PH_WEN:  tx = OPC_WREN;
      PH_POLL: tx = (idx_q == '0) ? OPC_RDSR : 8'h00;
      default: begin
        if (idx_q == LW'(0))      tx = main_opc(op_q);
        else if (idx_q == LW'(1)) tx = addr_q[23:16];
        else if (idx_q == LW'(2)) tx = addr_q[15:8];
        else if (idx_q == LW'(3)) tx = addr_q[7:0];
        else                      tx = buf_rd;
      end
    endcase
  end

  assign end_off = (LW + 1)'(cmd_addr[BW-1:0]) + (LW + 1)'(cmd_len);
  assign bad = (cmd_op > OP_WAKE) ||
               (pd_q && (cmd_op != OP_WAKE)) ||
               ((cmd_op == OP_PROG) &&
                ((cmd_len == '0) || (end_off > (LW + 1)'(PAGE))));

  always_comb begin
    st_n   = st_q;
    ph_n   = ph_q;
    op_n   = op_q;
    addr_n = addr_q;
    len_n  = len_q;
    idx_n  = idx_q;
    gap_n  = gap_q;
    poll_n = poll_q;
    pd_n   = pd_q;
    wip_n  = wip_q;
    done_n = 1'b0;
    err_n  = 1'b0;
    start  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          if (bad) begin
            err_n = 1'b1;
          end else begin
            op_n   = cmd_op;
            addr_n = cmd_addr;
            len_n  = cmd_len;
            idx_n  = '0;
            poll_n = '0;
            ph_n   = is_modify(cmd_op) ? PH_WEN : PH_MAIN;
            st_n   = ST_LOAD;
          end
        end
      end
      ST_LOAD: begin
        start = 1'b1;
        st_n  = ST_WAIT;
      end
      ST_WAIT: begin
        if (byte_done) begin
          if (ph_q == PH_POLL) wip_n = rx_last;
          if (idx_q == flen - LW'(1)) begin
            st_n  = ST_GAP;
            gap_n = '0;
          end else begin
            idx_n = idx_q + LW'(1);
            st_n  = ST_LOAD;
          end
        end
      end
      default: begin
        if (gap_q == GW'(GAP - 1)) begin
          idx_n = '0;
          case (ph_q)
            PH_WEN: begin
              ph_n = PH_MAIN;
              st_n = ST_LOAD;
            end
            PH_MAIN: begin
              if (is_modify(op_q)) begin
                ph_n = PH_POLL;
                st_n = ST_LOAD;
              end else begin
                pd_n   = (op_q == OP_SLEEP);
                done_n = 1'b1;
                st_n   = ST_IDLE;
              end
            end
            default: begin
              if (!wip_q) begin
                done_n = 1'b1;
                st_n   = ST_IDLE;
              end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                err_n = 1'b1;
                st_n  = ST_IDLE;
              end else begin
                poll_n = poll_q + PW'(1);
                st_n   = ST_LOAD;
              end
            end
          endcase
        end else begin
          gap_n = gap_q + GW'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q   <= ST_IDLE;
      ph_q   <= PH_WEN;
      op_q   <= '0;
      addr_q <= '0;
      len_q  <= '0;
      idx_q  <= '0;
      gap_q  <= '0;
      poll_q <= '0;
      pd_q   <= 1'b0;
      wip_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      ph_q   <= ph_n;
      op_q   <= op_n;
      addr_q <= addr_n;
      len_q  <= len_n;
      idx_q  <= idx_n;
      gap_q  <= gap_n;
      poll_q <= poll_n;
      pd_q   <= pd_n;
      wip_q  <= wip_n;
      done_q <= done_n;
      err_q  <= err_n;
    end
  end

  assign cmd_ready = (st_q == ST_IDLE);
  assign cs_n      = !((st_q == ST_LOAD) || (st_q == ST_WAIT));
  assign done      = done_q;
  assign err       = err_q;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int GAP = 8,
  localparam int CW = $clog2(GAP + 1)
) (
  input logic clk,
  input logic rst_n,
  input logic cpol,
  input logic cs_n,
  input logic sck,
  input logic mosi,
  input logic done,
  input logic err,
  input logic cmd_ready
);
  logic [CW-1:0] hi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hi_q <= CW'(GAP);
    else if (!cs_n)               hi_q <= '0;
    else if (hi_q < CW'(GAP))     hi_q <= hi_q + CW'(1);
  end

  AST_IDLE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (sck == cpol)); // R2
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $rose(sck)) |-> $stable(mosi)); // R3
  AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $past(cs_n)) |-> (hi_q >= CW'(GAP))); // R10
  AST_NO_FRAME_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> cs_n); // R13
  AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err)); // R13
endmodule

bind sflash_ctrl sfc_checker #(.GAP(4 * CLK_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpol      (cpol),
  .cs_n      (cs_n),
  .sck       (sck),
  .mosi      (mosi),
  .done      (done),
  .err       (err),
  .cmd_ready (cmd_ready)
);

// File: tb/sim_sflash_ctrl.sv
module sim_sflash_ctrl;
  localparam int DIV = 2;
  localparam int PL  = 8;
  localparam int GAP = 4 * DIV;
  localparam int NV  = 14;

  // {op[40:38], addr[37:14], len[13:5], wip[4:1], mode[0]}
  localparam logic [40:0] VEC [NV] = '{
    {3'd0, 24'h012300, 9'd4,   4'd2, 1'b0},
    {3'd1, 24'h0A5000, 9'd0,   4'd3, 1'b1},
    {3'd2, 24'h000000, 9'd0,   4'd0, 1'b0},
    {3'd0, 24'h0000F0, 9'd16,  4'd0, 1'b1},
    {3'd0, 24'h0000F1, 9'd16,  4'd0, 1'b0},
    {3'd0, 24'h000010, 9'd0,   4'd0, 1'b0},
    {3'd0, 24'h030000, 9'd256, 4'd1, 1'b1},
    {3'd1, 24'h001000, 9'd0,   4'd9, 1'b0},
    {3'd3, 24'h000000, 9'd0,   4'd0, 1'b1},
    {3'd1, 24'h002000, 9'd0,   4'd0, 1'b0},
    {3'd0, 24'h000000, 9'd4,   4'd0, 1'b1},
    {3'd4, 24'h000000, 9'd0,   4'd0, 1'b0},
    {3'd7, 24'h000000, 9'd0,   4'd0, 1'b1},
    {3'd1, 24'h7FF000, 9'd0,   4'd0, 1'b1}
  };

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        cpol = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [23:0] cmd_addr = '0;
  logic [8:0]  cmd_len = '0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic        done, err, sck, cs_n, mosi;
  logic        miso = 1'b0;

  sflash_ctrl #(.CLK_DIV(DIV), .POLL_LIMIT(PL)) u0 (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .done(done), .err(err), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int nchk = 0, nfail = 0, cyc = 0;

  // Flash model, sampled on the falling system clock edge
  logic [7:0] cb [2048];
  int fst [64];
  int fln [64];
  int nby = 0, nfr = 0, bitc = 0, hi_cnt = 1000;
  int gap_bad = 0, idle_bad = 0, wip_left = 0, ndone = 0, nerr = 0;
  logic [7:0] shr = '0;
  logic psck = 1'b0, pcs = 1'b1;
  logic [7:0] stat;

  assign stat = 8'hFC | {7'd0, (wip_left > 0)};

  always @(negedge clk) begin
    if (done) ndone++;
    if (err)  nerr++;
    if (!cs_n && pcs && nfr < 64) begin
      fst[nfr] = nby;
      bitc = 0;
      if (hi_cnt < GAP) gap_bad++;
    end
    if (cs_n) begin
      hi_cnt++;
      if (sck !== cpol) idle_bad++;
      if (!pcs && nfr < 64) begin
        fln[nfr] = nby - fst[nfr];
        if (fln[nfr] > 0 && cb[fst[nfr]] == 8'h05 && wip_left > 0) wip_left--;
        nfr++;
      end
    end else begin
      hi_cnt = 0;
      if (sck && !psck) begin
        shr = {shr[6:0], mosi};
        bitc++;
        if (bitc == 8) begin
          if (nby < 2048) cb[nby] = shr;
          nby++;
          bitc = 0;
        end
      end
    end
    miso = (!cs_n && nfr < 64 && (nby - fst[nfr]) == 1) ? stat[7 - bitc] : 1'b0;
    psck = sck;
    pcs  = cs_n;
  end

  // Expected frames
  logic [7:0] eb [2048];
  int efst [64];
  int efln [64];
  int neb = 0, nef = 0;
  logic pd_m = 1'b0;

  task automatic eopen();  efst[nef] = neb; endtask
  task automatic eput(input logic [7:0] b); eb[neb] = b; neb++; endtask
  task automatic eclose(); efln[nef] = neb - efst[nef]; nef++; endtask

  function automatic logic [7:0] dat(input int k, input int seed);
    return 8'((k * 37 + seed) & 255);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic run_op(input logic [2:0] op, input logic [23:0] addr,
                        input logic [8:0] len, input int wip, input logic mode);
    int seed;
    bit rej, modop, exp_err;
    int npoll;
    string rtag, ftag;
    seed = int'(addr[7:0]) ^ int'(len[7:0]);
    tick(1);
    cpol = mode;
    tick(2);
    if (op == 3'd0) begin
      for (int k = 0; k < int'(len) && k < 256; k++) begin
        wr_en = 1'b1; wr_addr = 8'(k); wr_data = dat(k, seed);
        tick(1);
      end
      wr_en = 1'b0;
    end
    rej = (op > 3'd4) || (pd_m && op != 3'd4) ||
          (op == 3'd0 && (len == 0 || int'(addr[7:0]) + int'(len) > 256));
    rtag = (op > 3'd4) ? "R12" : (pd_m && op != 3'd4) ? "R11" : "R7";
    modop = (op <= 3'd2);
    npoll = (wip >= PL) ? PL : wip + 1;
    exp_err = rej || (modop && wip >= PL);
    nef = 0; neb = 0;
    if (!rej) begin
      if (modop) begin eopen(); eput(8'h06); eclose(); end
      eopen();
      case (op)
        3'd0: eput(8'h02);
        3'd1: eput(8'hD8);
        3'd2: eput(8'hC7);
        3'd3: eput(8'hB9);
        default: eput(8'hAB);
      endcase
      if (op <= 3'd1) begin eput(addr[23:16]); eput(addr[15:8]); eput(addr[7:0]); end
      if (op == 3'd0) for (int k = 0; k < int'(len); k++) eput(dat(k, seed));
      eclose();
      if (modop) for (int p = 0; p < npoll; p++) begin
        eopen(); eput(8'h05); eput(8'h00); eclose();
      end
    end
    nfr = 0; nby = 0; ndone = 0; nerr = 0; gap_bad = 0; idle_bad = 0;
    wip_left = wip;
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_len = len;
    tick(1);
    cmd_valid = 1'b0;
    if (!rej) begin
      tick(3);
      chk(cmd_ready == 1'b0, "R13", "ready during op", int'(cmd_ready), 0);
    end
    while (ndone + nerr == 0) @(negedge clk);
    tick(3);
    if (rej)            chk(nerr == 1 && nfr == 0, rtag, "refused op", nerr * 100 + nfr, 100);
    else if (exp_err)   chk(nerr == 1, "R9", "poll limit err", nerr, 1);
    else if (modop)     chk(ndone == 1, "R8", "done after poll", ndone, 1);
    else                chk(ndone == 1, "R11", "power op done", ndone, 1);
    chk(ndone + nerr == 1, "R13", "single result", ndone + nerr, 1);
    chk(nfr == nef, "R4", "frame count", nfr, nef);
    for (int f = 0; f < nef && f < nfr; f++) begin
      int bad_at;
      bad_at = -1;
      if (fln[f] == efln[f]) begin
        for (int b = 0; b < efln[f]; b++)
          if (bad_at < 0 && cb[fst[f] + b] !== eb[efst[f] + b]) bad_at = b;
      end else bad_at = 9999;
      if (eb[efst[f]] == 8'h06)      ftag = "R4";
      else if (eb[efst[f]] == 8'h02) ftag = "R3 R5";
      else if (eb[efst[f]] == 8'h05) ftag = "R8";
      else if (eb[efst[f]] == 8'hD8 || eb[efst[f]] == 8'hC7) ftag = "R6";
      else                            ftag = "R11";
      chk(bad_at < 0, ftag, "frame content (len/first bad pos)",
          fln[f] * 65536 + bad_at, efln[f] * 65536 - 1);
    end
    chk(gap_bad == 0, "R10", "short cs high gap", gap_bad, 0);
    chk(idle_bad == 0, "R2", "sck idle level", idle_bad, 0);
    if (!rej && op == 3'd3) pd_m = 1'b1;
    if (!rej && op == 3'd4) pd_m = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      nchk++; nfail++;
      $display("FAIL R13 watchdog: actual hang expected finish");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    tick(2);
    chk(cs_n == 1'b1 && done == 1'b0 && err == 1'b0, "R1", "outputs in reset",
        {cs_n, done, err}, 3'b100);
    chk(sck == 1'b0, "R1", "sck in reset mode0", sck, 0);
    cpol = 1'b1;
    tick(1);
    chk(sck == 1'b1, "R2", "sck idle mode3", sck, 1);
    cpol = 1'b0;
    rst_n = 1'b1;
    tick(5);
    chk(cmd_ready == 1'b1 && cs_n == 1'b1, "R1", "ready after reset",
        {cmd_ready, cs_n}, 2'b11);

    for (int v = 0; v < NV; v++)
      run_op(VEC[v][40:38], VEC[v][37:14], VEC[v][13:5],
             int'(VEC[v][4:1]), VEC[v][0]);

    // Directed corners: last byte of a page, and an oversize length
    run_op(3'd0, 24'h0400FF, 9'd1, 0, 1'b0);
    run_op(3'd0, 24'h050000, 9'd257, 0, 1'b1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule